// File: doc/BRIEF.md
# Dual Halfword Signed Multiply Unit

This block carries out one packed multiply instruction for a media coprocessor. It accepts a 32-bit instruction word with an issue strobe and decodes four register indices, a 2-bit pairing mode and a 2-bit variant select. It reads two 32-bit sources from a local 16-entry register file and splits each source into two signed 16-bit halves. Two signed 16x16 multipliers then form a left and a right 32-bit product. The products are written back to two destination entries at the clock edge that accepts the instruction.

The mode picks which halves meet. The high half of the second source always feeds the left product, and its low half always feeds the right product. The mode only decides which half of the first source joins each of them. One variant select value is reserved. It produces a one-cycle illegal-instruction flag, and neither destination is written.

The surrounding pipeline reaches the register file through one load port and one observation read port. These carry the move-to and move-from traffic of the other media instructions. A completion pulse follows every accepted instruction by one cycle.

Top module: `dual_half_mul_unit`

## Requirements
- R1: An instruction is accepted only when `issue_valid` is high, bits 31:26 equal 6'b011100 and bits 5:0 equal 6'b001000. Any other word leaves every register unchanged and produces no `done_o` pulse.
- R2: Field positions are fixed:
  - bits 9:6 give the left destination;
  - bits 13:10 give source B;
  - bits 17:14 give source C;
  - bits 21:18 give the right destination;
  - bits 23:22 give the mode;
  - bits 25:24 give the variant select.
- R3: Each source splits into a high half (bits 31:16) and a low half (bits 15:0). Both halves are signed 16-bit values, and each product is a full 32-bit signed result.
- R4: Mode 0 gives left = B.high*C.high and right = B.low*C.low.
- R5: Mode 1 gives left = B.low*C.high and right = B.low*C.low.
- R6: Mode 2 gives left = B.high*C.high and right = B.high*C.low.
- R7: Mode 3 gives left = B.low*C.high and right = B.high*C.low.
- R8: On acceptance, the left product goes to the left destination and the right product to the right destination. Both are readable, and `done_o` is high for exactly one cycle, in the cycle after the accepting edge.
- R9: A variant select of 1 writes no destination. Instead, `illegal_o` and `done_o` are both high for one cycle. The variant select values 0, 2 and 3 execute normally.
- R10: Entry 0 always reads as zero, and writes to it have no effect.
- R11: When both destinations name the same entry, that entry takes the right product.
- R12: After reset, `done_o` and `illegal_o` are low and every entry reads zero.
- R13: The load port writes `ld_data` to entry `ld_addr` at the edge where `ld_en` is high. If an accepted instruction writes the same entry in that cycle, the instruction's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Instruction word is presented this cycle |
| instr | input | 32 | Instruction word |
| ld_en | input | 1 | Load-port write enable |
| ld_addr | input | 4 | Load-port entry index |
| ld_data | input | 32 | Load-port write data |
| obs_addr | input | 4 | Observation read index |
| obs_data | output | 32 | Combinational read of entry `obs_addr` |
| done_o | output | 1 | One-cycle pulse after an accepted instruction |
| illegal_o | output | 1 | One-cycle reserved-variant flag, aligned with `done_o` |

## Verification
The embedded properties watch several rules on every cycle:
- a reserved select is always followed by the illegal flag together with the completion pulse;
- the completion pulse never appears without an issue one cycle earlier;
- a doubly named destination always ends up holding the right product;
- each lane's product sign and zero behaviour agree with its operand signs.

The numeric content of the products for each mode, the extreme halfword values, and the untouched destinations after a trap or an unrecognised word can only be shown by the bench's scenarios. The same holds for the entry-0 rule and the load-port priority; the bench reads these back through the observation port.

// File: rtl/dmul_pkg.sv
// Package: shared encodings and decoded-instruction type for the dual
// halfword multiply unit. Assumes the fixed 32-bit instruction layout.
package dmul_pkg;
    localparam int INSTR_W  = 32;
    localparam int IDX_W    = 4;
    localparam int MODE_W   = 2;
    localparam int VSEL_W   = 2;
    localparam int OPC_W    = 6;

    localparam logic [OPC_W-1:0]  MAJOR_OP   = 6'b011100;
    localparam logic [OPC_W-1:0]  FUNC_DMUL  = 6'b001000;
    localparam logic [VSEL_W-1:0] VSEL_RSVD  = 2'd1;

    // Bit positions the decoder extracts (behaviour-defining).
    localparam int POS_DST_L = 6;
    localparam int POS_SRC_B = 10;
    localparam int POS_SRC_C = 14;
    localparam int POS_DST_R = 18;
    localparam int POS_MODE  = 22;
    localparam int POS_VSEL  = 24;
    localparam int POS_MAJOR = 26;

    typedef enum logic [MODE_W-1:0] {
        PAIR_HH_LL = 2'd0,
        PAIR_LH_LL = 2'd1,
        PAIR_HH_HL = 2'd2,
        PAIR_LH_HL = 2'd3
    } pair_mode_e;

    typedef struct packed {
        logic             hit;
        logic             trap;
        pair_mode_e       mode;
        logic [IDX_W-1:0] dst_l;
        logic [IDX_W-1:0] src_b;
        logic [IDX_W-1:0] src_c;
        logic [IDX_W-1:0] dst_r;
    } dmul_dec_t;
endpackage

// File: rtl/dmul_decode.sv
// Module: dmul_decode
// Combinational decoder. Recognises the packed multiply encoding and
// extracts register indices, pairing mode and the reserved-variant trap.
// Assumes the caller qualifies the result with its own issue strobe.
module dmul_decode
    import dmul_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dmul_dec_t          dec
);
    logic [VSEL_W-1:0] vsel;

    // Pull fields out of the word and classify it.
    always_comb begin
        vsel      = instr[POS_VSEL +: VSEL_W];
        dec.hit   = (instr[POS_MAJOR +: OPC_W] == MAJOR_OP) &&
                    (instr[OPC_W-1:0] == FUNC_DMUL);
        dec.trap  = dec.hit && (vsel == VSEL_RSVD);
        dec.mode  = pair_mode_e'(instr[POS_MODE +: MODE_W]);
        dec.dst_l = instr[POS_DST_L +: IDX_W];
        dec.src_b = instr[POS_SRC_B +: IDX_W];
        dec.src_c = instr[POS_SRC_C +: IDX_W];
        dec.dst_r = instr[POS_DST_R +: IDX_W];
    end
endmodule

// File: rtl/dmul_operand_sel.sv
// Module: dmul_operand_sel
// Splits both sources into signed halves and routes them to the two lanes.
// C.high always feeds the left lane and C.low the right lane; the mode
// chooses which half of B joins each lane.
module dmul_operand_sel
    import dmul_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2,
    localparam int LANES  = 2
) (
    input  logic [DATA_W-1:0]        src_b,
    input  logic [DATA_W-1:0]        src_c,
    input  pair_mode_e               mode,
    output logic signed [HALF_W-1:0] op_x [LANES],
    output logic signed [HALF_W-1:0] op_y [LANES]
);
    logic signed [HALF_W-1:0] b_hi, b_lo, c_hi, c_lo;

    // Separate the halfwords of each source.
    always_comb begin
        b_hi = src_b[DATA_W-1:HALF_W];
        b_lo = src_b[HALF_W-1:0];
        c_hi = src_c[DATA_W-1:HALF_W];
        c_lo = src_c[HALF_W-1:0];
    end

    // Steer B halves per pairing mode; lane 0 is left, lane 1 is right.
    always_comb begin
        unique case (mode)
            PAIR_HH_LL: begin op_x[0] = b_hi; op_x[1] = b_lo; end
            PAIR_LH_LL: begin op_x[0] = b_lo; op_x[1] = b_lo; end
            PAIR_HH_HL: begin op_x[0] = b_hi; op_x[1] = b_hi; end
            default:    begin op_x[0] = b_lo; op_x[1] = b_hi; end
        endcase
        op_y[0] = c_hi;
        op_y[1] = c_lo;
    end
endmodule

// File: rtl/dmul_lane_mult.sv
// Module: dmul_lane_mult
// One signed HALF_W x HALF_W multiplier producing a 2*HALF_W result.
// Clock and reset are present only for the embedded checks.
module dmul_lane_mult #(
    parameter int HALF_W = 16,
    localparam int PROD_W = 2 * HALF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [HALF_W-1:0] a,
    input  logic signed [HALF_W-1:0] b,
    output logic signed [PROD_W-1:0] p
);
    // Full-width signed product.
    always_comb begin
        p = PROD_W'(a) * PROD_W'(b);
    end

    // R3
    prod_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a != 0 && b != 0) |-> (p[PROD_W-1] == (a[HALF_W-1] ^ b[HALF_W-1])));

    // R3
    prod_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a == 0 || b == 0) |-> (p == 0));
endmodule

// File: rtl/dmul_regfile.sv
// Module: dmul_regfile
// Media register file: REGS entries, three combinational read ports and
// WR_PORTS synchronous write ports, highest port index wins on collision.
// Entry 0 is hard-wired to zero. Synchronous active-low reset clears all.
module dmul_regfile #(
    parameter int DATA_W   = 32,
    parameter int REGS     = 16,
    parameter int WR_PORTS = 3,
    localparam int IDX_W   = $clog2(REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we    [WR_PORTS],
    input  logic [IDX_W-1:0]  waddr [WR_PORTS],
    input  logic [DATA_W-1:0] wdata [WR_PORTS],
    input  logic [IDX_W-1:0]  ra_b,
    input  logic [IDX_W-1:0]  ra_c,
    input  logic [IDX_W-1:0]  ra_obs,
    output logic [DATA_W-1:0] rd_b,
    output logic [DATA_W-1:0] rd_c,
    output logic [DATA_W-1:0] rd_obs
);
    logic [DATA_W-1:0] mem [REGS];

    for (genvar e = 0; e < REGS; e++) begin : g_entry
        if (e == 0) begin : g_zero
            assign mem[e] = '0;
        end else begin : g_store
            logic              hit;
            logic [DATA_W-1:0] nxt;

            // Resolve which write port lands here, last port winning.
            always_comb begin
                hit = 1'b0;
                nxt = mem[e];
                for (int w = 0; w < WR_PORTS; w++) begin
                    if (we[w] && (waddr[w] == IDX_W'(e))) begin
                        hit = 1'b1;
                        nxt = wdata[w];
                    end
                end
            end

            // Hold or update the entry.
            always_ff @(posedge clk) begin
                if (!rst_n)   mem[e] <= '0;
                else if (hit) mem[e] <= nxt;
            end
        end
    end

    // Read ports.
    always_comb begin
        rd_b   = mem[ra_b];
        rd_c   = mem[ra_c];
        rd_obs = mem[ra_obs];
    end

    // R11
    last_port_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we[WR_PORTS-1] && we[WR_PORTS-2] &&
         waddr[WR_PORTS-1] == waddr[WR_PORTS-2] && waddr[WR_PORTS-1] != '0)
        |=> (mem[$past(waddr[WR_PORTS-1])] == $past(wdata[WR_PORTS-1])));
endmodule

// File: rtl/dual_half_mul_unit.sv
// Module: dual_half_mul_unit
// Top level: decodes the packed dual halfword multiply, reads two sources,
// multiplies two lanes and writes both products in the accepting cycle.
// Assumes one instruction per issue strobe; the load port has the lowest
// write priority, then the left result, then the right result.
module dual_half_mul_unit
    import dmul_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int REGS   = 1 << IDX_W,
    localparam int HALF_W = DATA_W / 2,
    localparam int LANES  = 2,
    localparam int WR_P   = LANES + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic               ld_en,
    input  logic [IDX_W-1:0]   ld_addr,
    input  logic [DATA_W-1:0]  ld_data,
    input  logic [IDX_W-1:0]   obs_addr,
    output logic [DATA_W-1:0]  obs_data,
    output logic               done_o,
    output logic               illegal_o
);
    dmul_dec_t                dec;
    logic                     accept, commit;
    logic [DATA_W-1:0]        src_b, src_c;
    logic signed [HALF_W-1:0] op_x [LANES];
    logic signed [HALF_W-1:0] op_y [LANES];
    logic signed [DATA_W-1:0] prod [LANES];
    logic                     we    [WR_P];
    logic [IDX_W-1:0]         waddr [WR_P];
    logic [DATA_W-1:0]        wdata [WR_P];

    dmul_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    // Qualify the decode with the issue strobe.
    always_comb begin
        accept = issue_valid && dec.hit;
        commit = accept && !dec.trap;
    end

    dmul_operand_sel #(.DATA_W(DATA_W)) u_sel (
        .src_b (src_b),
        .src_c (src_c),
        .mode  (dec.mode),
        .op_x  (op_x),
        .op_y  (op_y)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        dmul_lane_mult #(.HALF_W(HALF_W)) u_mul (
            .clk   (clk),
            .rst_n (rst_n),
            .a     (op_x[l]),
            .b     (op_y[l]),
            .p     (prod[l])
        );
    end

    // Assemble write ports: load port first, then left, then right.
    always_comb begin
        we[0]    = ld_en;
        waddr[0] = ld_addr;
        wdata[0] = ld_data;
        we[1]    = commit;
        waddr[1] = dec.dst_l;
        wdata[1] = prod[0];
        we[2]    = commit;
        waddr[2] = dec.dst_r;
        wdata[2] = prod[1];
    end

    dmul_regfile #(.DATA_W(DATA_W), .REGS(REGS), .WR_PORTS(WR_P)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wdata),
        .ra_b   (dec.src_b),
        .ra_c   (dec.src_c),
        .ra_obs (obs_addr),
        .rd_b   (src_b),
        .rd_c   (src_c),
        .rd_obs (obs_data)
    );

    // Completion and trap flags, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            done_o    <= accept;
            illegal_o <= accept && dec.trap;
        end
    end

    // R9
    trap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && instr[POS_MAJOR +: OPC_W] == MAJOR_OP &&
         instr[OPC_W-1:0] == FUNC_DMUL && instr[POS_VSEL +: VSEL_W] == VSEL_RSVD)
        |=> (illegal_o && done_o));

    // R9
    trap_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> done_o);

    // R1
    done_needs_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(issue_valid));
endmodule

// File: tb/test_dual_half_mul_unit.sv
module test_dual_half_mul_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [3:0]  obs_addr = '0;
    logic [31:0] obs_data;
    logic        done_o, illegal_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dual_half_mul_unit i_dual_half_mul_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .obs_addr(obs_addr), .obs_data(obs_data),
        .done_o(done_o), .illegal_o(illegal_o)
    );

    // stimulus: B, C, mode
    typedef struct packed {
        logic [31:0] b;
        logic [31:0] c;
        logic [1:0]  mode;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{32'h0003_0005, 32'h0007_000B, 2'd0},
        '{32'h0003_0005, 32'h0007_000B, 2'd1},
        '{32'h0003_0005, 32'h0007_000B, 2'd2},
        '{32'h0003_0005, 32'h0007_000B, 2'd3},
        '{32'hFFFF_8000, 32'h8000_7FFF, 2'd0},
        '{32'h8000_FFFE, 32'h8000_0002, 2'd1},
        '{32'h7FFF_8000, 32'h7FFF_8000, 2'd2},
        '{32'hFFF0_0010, 32'h0100_FF00, 2'd3},
        '{32'h1234_ABCD, 32'h0000_0000, 2'd0},
        '{32'h8000_8000, 32'h8000_8000, 2'd3}
    };

    function automatic logic [31:0] mul16(input logic [15:0] x, input logic [15:0] y);
        longint sx, sy;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        return 32'(sx * sy);
    endfunction

    // Expected products from R4..R7 (lane 0 left, lane 1 right).
    function automatic logic [31:0] ref_prod(input logic [31:0] b, input logic [31:0] c,
                                             input logic [1:0] mode, input bit right);
        case (mode)
            2'd0: return right ? mul16(b[15:0],  c[15:0]) : mul16(b[31:16], c[31:16]);
            2'd1: return right ? mul16(b[15:0],  c[15:0]) : mul16(b[15:0],  c[31:16]);
            2'd2: return right ? mul16(b[31:16], c[15:0]) : mul16(b[31:16], c[31:16]);
            default: return right ? mul16(b[31:16], c[15:0]) : mul16(b[15:0], c[31:16]);
        endcase
    endfunction

    function automatic logic [31:0] mk(input logic [1:0] vsel, input logic [1:0] mode,
                                       input logic [3:0] dl, input logic [3:0] sb,
                                       input logic [3:0] sc, input logic [3:0] dr);
        return {6'b011100, vsel, mode, dr, sc, sb, dl, 6'b001000};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Present one instruction; returns at the negedge where done_o is visible.
    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        issue_valid = 1'b1; instr = w;
        @(negedge clk);
        issue_valid = 1'b0; instr = '0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] d);
        obs_addr = a;
        #1;
        d = obs_data;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        check("R12 done", {31'd0, done_o}, 32'd0);
        check("R12 illegal", {31'd0, illegal_o}, 32'd0);
        for (int i = 0; i < 16; i += 5) begin
            peek(4'(i), v);
            check("R12 entry", v, 32'd0);
        end

        // R2 R3 R4 R5 R6 R7 R8: table walk, left->3, right->4
        for (int k = 0; k < 10; k++) begin
            load(4'd1, VECS[k].b);
            load(4'd2, VECS[k].c);
            issue(mk(2'd0, VECS[k].mode, 4'd3, 4'd1, 4'd2, 4'd4));
            check("R8 done pulse", {31'd0, done_o}, 32'd1);
            peek(4'd3, v);
            check($sformatf("R4-7 left vec%0d", k), v, ref_prod(VECS[k].b, VECS[k].c, VECS[k].mode, 1'b0));
            peek(4'd4, v);
            check($sformatf("R4-7 right vec%0d", k), v, ref_prod(VECS[k].b, VECS[k].c, VECS[k].mode, 1'b1));
            @(negedge clk);
            check("R8 done single", {31'd0, done_o}, 32'd0);
        end

        // R2: other index placement, variant 2 executes (R9)
        load(4'd9, 32'hFFFE_0003);
        load(4'd12, 32'h0004_FFF9);
        issue(mk(2'd2, 2'd0, 4'd14, 4'd9, 4'd12, 4'd7));
        check("R9 illegal low for vsel2", {31'd0, illegal_o}, 32'd0);
        peek(4'd14, v);
        check("R2 left dst", v, 32'hFFFF_FFF8);
        peek(4'd7, v);
        check("R2 right dst", v, 32'hFFFF_FFEB);

        // R9: reserved variant, destinations keep preloaded values
        load(4'd5, 32'hAAAA_5555);
        load(4'd6, 32'h1357_2468);
        issue(mk(2'd1, 2'd0, 4'd5, 4'd9, 4'd12, 4'd6));
        check("R9 illegal", {31'd0, illegal_o}, 32'd1);
        check("R9 done", {31'd0, done_o}, 32'd1);
        peek(4'd5, v);
        check("R9 left untouched", v, 32'hAAAA_5555);
        peek(4'd6, v);
        check("R9 right untouched", v, 32'h1357_2468);
        @(negedge clk);
        check("R9 illegal one cycle", {31'd0, illegal_o}, 32'd0);

        // R1: wrong function code and no strobe are ignored
        issue(mk(2'd0, 2'd0, 4'd5, 4'd9, 4'd12, 4'd6) | 32'h1);
        check("R1 no done", {31'd0, done_o}, 32'd0);
        peek(4'd5, v);
        check("R1 dst untouched", v, 32'hAAAA_5555);
        @(negedge clk);
        instr = mk(2'd0, 2'd0, 4'd5, 4'd9, 4'd12, 4'd6);
        @(negedge clk);
        instr = '0;
        check("R1 no strobe", {31'd0, done_o}, 32'd0);
        peek(4'd6, v);
        check("R1 dst untouched no strobe", v, 32'h1357_2468);

        // R10: entry 0 ignores load and instruction writes
        load(4'd0, 32'hDEAD_BEEF);
        peek(4'd0, v);
        check("R10 load to zero", v, 32'd0);
        issue(mk(2'd0, 2'd0, 4'd0, 4'd9, 4'd12, 4'd0));
        peek(4'd0, v);
        check("R10 result to zero", v, 32'd0);

        // R11: same destination takes the right product
        issue(mk(2'd0, 2'd0, 4'd8, 4'd9, 4'd12, 4'd8));
        peek(4'd8, v);
        check("R11 right wins", v, 32'hFFFF_FFEB);

        // R13: load to same entry as a result in the same cycle loses
        @(negedge clk);
        issue_valid = 1'b1; instr = mk(2'd0, 2'd0, 4'd10, 4'd9, 4'd12, 4'd11);
        ld_en = 1'b1; ld_addr = 4'd10; ld_data = 32'h0BAD_F00D;
        @(negedge clk);
        issue_valid = 1'b0; instr = '0; ld_en = 1'b0;
        peek(4'd10, v);
        check("R13 instruction wins", v, 32'hFFFF_FFF8);
        load(4'd13, 32'h0BAD_F00D);
        peek(4'd13, v);
        check("R13 plain load", v, 32'h0BAD_F00D);

        finish_run();
    end
endmodule